// File: doc/BRIEF.md
# Earliest/Latest Start-Step Scheduler

This block computes two unconstrained schedules for a small directed acyclic task graph. Each node is a task with a latency of one to three cycles. Each arc is a data dependency: a predecessor must finish before its successor may start. The graph is held in registers. A write port loads one node per transfer, carrying the node's latency and a bitmask of its predecessors.

A start pulse launches a run over the first `num_nodes` nodes. The engine first makes forward passes. In each pass it places every node whose predecessors are all placed, which gives the earliest start step of each node. The largest finish step then becomes the critical-path length. Backward passes use that length as the deadline and place every node whose successors are all placed, which gives the latest start step. The difference between the two steps is the node's slack, which a later priority-driven scheduler can use. Results are read through an indexed, combinational read port.

The write port follows valid/ready rules. A node is written on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole run, so a writer must hold its data until the run ends. Control pins (`start`, `done`, `err`) are plain levels and pulses.

Top module: `hls_slot_sched`

## Requirements
- R1: A node entry is written on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high exactly while no run is in progress, so a write offered during a run is not stored. A write accepted on the same edge as `start` is part of that run.
- R2: The latency field is 2 bits wide and holds the latency in cycles. A written code of 0 is stored as latency 1.
- R3: The earliest start of a node with no active predecessors is step 0. Any other node starts at the largest value of (predecessor earliest start + predecessor latency).
- R4: `crit_len` is the largest value of (earliest start + latency) over the active nodes. For the 11-node reference graph with unit latencies it equals 4.
- R5: The latest start of a node with no active successors is `crit_len` minus its latency. Any other node starts at the smallest successor latest start, minus its own latency.
- R6: `rd_slack` is the latest start minus the earliest start of the node at `rd_idx`. It is 0 for every node on a critical path.
- R7: Nodes with index at or above `num_nodes` (sampled at start) are inactive. Mask bits that point at them are ignored, and their three results read 0 after the run.
- R8: When both schedules are complete, `done` rises and stays high until the next accepted start. If a pass places nothing while active nodes remain (a dependency cycle), `err` rises instead and `done` stays low. `num_nodes` = 0 completes with `crit_len` 0.
- R9: `start` is ignored during a run. An accepted start clears `done`, `err` and all results.
- R10: After reset, `wr_ready` is 1, `done`, `err` and `crit_len` are 0, and all results read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Node entry offered |
| wr_ready | output | 1 | Entry can be taken (no run in progress) |
| wr_addr | input | IDX_W | Node index being written |
| wr_lat | input | LAT_W | Node latency in cycles (0 stored as 1) |
| wr_pred | input | N | Predecessor bitmask, bit j = node j |
| num_nodes | input | CNT_W | Number of active nodes, sampled at start |
| start | input | 1 | Start pulse |
| done | output | 1 | Both schedules complete |
| err | output | 1 | Run stopped on an unschedulable graph |
| crit_len | output | STEP_W | Critical-path length in steps |
| rd_idx | input | IDX_W | Node index to read |
| rd_asap | output | STEP_W | Earliest start step of the selected node |
| rd_alap | output | STEP_W | Latest start step of the selected node |
| rd_slack | output | STEP_W | Slack of the selected node |

## Verification
Loading and launching can fall in the same cycle. A node write can be accepted on the very edge that accepts `start`, and the run must then use the new entry. The bench provokes this by offering a latency change together with the start pulse. It judges the result by the changed latest start and slack of that node. The opposite case is also tested: a write and a second start pulse offered one cycle into a run must both be refused. The bench judges this by `wr_ready` being low and by the unchanged results of this run and of the next one.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_BWD  = 2'd2
  } sched_state_e;
endpackage

// File: rtl/sched_graph_store.sv
module sched_graph_store #(
  parameter int N     = 16,
  parameter int LAT_W = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [LAT_W-1:0] wlat,
  input  logic [N-1:0]     wpred,
  output logic [LAT_W-1:0] lat  [N],
  output logic [N-1:0]     pred [N]
);
  // a zero latency code is not meaningful: store the minimum instead
  logic [LAT_W-1:0] wlat_fix;
  assign wlat_fix = (wlat == '0) ? LAT_W'(1) : wlat;

  for (genvar i = 0; i < N; i++) begin : g_node
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat[i]  <= LAT_W'(1);
        pred[i] <= '0;
      end else if (we && (waddr == IDX_W'(i))) begin
        lat[i]  <= wlat_fix;
        pred[i] <= wpred;
      end
    end
  end
endmodule

// File: rtl/sched_fwd_pass.sv
module sched_fwd_pass #(
  parameter int N      = 16,
  parameter int LAT_W  = 2,
  parameter int STEP_W = 6
) (
  input  logic [N-1:0]      act,
  input  logic [N-1:0]      placed,
  input  logic [N-1:0]      pred [N],
  input  logic [LAT_W-1:0]  lat  [N],
  input  logic [STEP_W-1:0] asap [N],
  output logic [N-1:0]      ready,
  output logic [STEP_W-1:0] val  [N],
  output logic [STEP_W-1:0] span
);
  // per node: placeable once no active predecessor is still open
  for (genvar i = 0; i < N; i++) begin : g_node
    always_comb begin
      logic [STEP_W-1:0] fin;
      ready[i] = act[i] && !placed[i] && ((pred[i] & act & ~placed) == '0);
      val[i]   = '0;
      for (int j = 0; j < N; j++) begin
        fin = asap[j] + STEP_W'(lat[j]);
        if (pred[i][j] && act[j] && (fin > val[i])) val[i] = fin;
      end
    end
  end

  // longest finish over the active set
  always_comb begin
    logic [STEP_W-1:0] f;
    span = '0;
    for (int j = 0; j < N; j++) begin
      f = asap[j] + STEP_W'(lat[j]);
      if (act[j] && (f > span)) span = f;
    end
  end
endmodule

// File: rtl/sched_bwd_pass.sv
module sched_bwd_pass #(
  parameter int N      = 16,
  parameter int LAT_W  = 2,
  parameter int STEP_W = 6
) (
  input  logic [N-1:0]      act,
  input  logic [N-1:0]      placed,
  input  logic [N-1:0]      pred [N],
  input  logic [LAT_W-1:0]  lat  [N],
  input  logic [STEP_W-1:0] alap [N],
  input  logic [STEP_W-1:0] deadline,
  output logic [N-1:0]      ready,
  output logic [STEP_W-1:0] val  [N]
);
  // successor relation is the transpose of the stored predecessor masks
  for (genvar i = 0; i < N; i++) begin : g_node
    always_comb begin
      logic              open_succ;
      logic [STEP_W-1:0] bound;
      open_succ = 1'b0;
      bound     = deadline;
      for (int j = 0; j < N; j++) begin
        if (pred[j][i] && act[j]) begin
          if (!placed[j]) open_succ = 1'b1;
          if (alap[j] < bound) bound = alap[j];
        end
      end
      ready[i] = act[i] && !placed[i] && !open_succ;
      val[i]   = bound - STEP_W'(lat[i]);
    end
  end
endmodule

// File: rtl/hls_slot_sched.sv
module hls_slot_sched
  import sched_pkg::*;
#(
  parameter int N     = 16,
  parameter int LAT_W = 2,
  localparam int MAX_LAT = (1 << LAT_W) - 1,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W   = $clog2(N + 1),
  localparam int STEP_W  = $clog2(N * MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [LAT_W-1:0]  wr_lat,
  input  logic [N-1:0]      wr_pred,
  input  logic [CNT_W-1:0]  num_nodes,
  input  logic              start,
  output logic              done,
  output logic              err,
  output logic [STEP_W-1:0] crit_len,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [STEP_W-1:0] rd_asap,
  output logic [STEP_W-1:0] rd_alap,
  output logic [STEP_W-1:0] rd_slack
);
  sched_state_e      state_q;
  logic [N-1:0]      act_q, fplaced_q, bplaced_q, act_start;
  logic [STEP_W-1:0] asap_q [N];
  logic [STEP_W-1:0] alap_q [N];
  logic [LAT_W-1:0]  lat    [N];
  logic [N-1:0]      pred   [N];
  logic [N-1:0]      fready, bready;
  logic [STEP_W-1:0] fval [N];
  logic [STEP_W-1:0] bval [N];
  logic [STEP_W-1:0] span;
  logic              busy, go;

  assign busy     = (state_q != ST_IDLE);
  assign wr_ready = !busy;
  assign go       = start && !busy;

  sched_graph_store #(.N(N), .LAT_W(LAT_W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_valid && wr_ready),
    .waddr(wr_addr),
    .wlat (wr_lat),
    .wpred(wr_pred),
    .lat  (lat),
    .pred (pred)
  );

  sched_fwd_pass #(.N(N), .LAT_W(LAT_W), .STEP_W(STEP_W)) u_fwd (
    .act   (act_q),
    .placed(fplaced_q),
    .pred  (pred),
    .lat   (lat),
    .asap  (asap_q),
    .ready (fready),
    .val   (fval),
    .span  (span)
  );

  sched_bwd_pass #(.N(N), .LAT_W(LAT_W), .STEP_W(STEP_W)) u_bwd (
    .act     (act_q),
    .placed  (bplaced_q),
    .pred    (pred),
    .lat     (lat),
    .alap    (alap_q),
    .deadline(crit_len),
    .ready   (bready),
    .val     (bval)
  );

  // active set from the node count at start
  always_comb begin
    for (int i = 0; i < N; i++) act_start[i] = (i < int'(num_nodes));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      crit_len  <= '0;
      act_q     <= '0;
      fplaced_q <= '0;
      bplaced_q <= '0;
      for (int i = 0; i < N; i++) begin
        asap_q[i] <= '0;
        alap_q[i] <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q   <= ST_FWD;
            done      <= 1'b0;
            err       <= 1'b0;
            crit_len  <= '0;
            act_q     <= act_start;
            fplaced_q <= '0;
            bplaced_q <= '0;
            for (int i = 0; i < N; i++) begin
              asap_q[i] <= '0;
              alap_q[i] <= '0;
            end
          end
        end
        ST_FWD: begin
          if (fplaced_q == act_q) begin
            crit_len <= span;
            state_q  <= ST_BWD;
          end else if (fready == '0) begin
            err     <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            fplaced_q <= fplaced_q | fready;
            for (int i = 0; i < N; i++)
              if (fready[i]) asap_q[i] <= fval[i];
          end
        end
        ST_BWD: begin
          if (bplaced_q == act_q) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (bready == '0) begin
            err     <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            bplaced_q <= bplaced_q | bready;
            for (int i = 0; i < N; i++)
              if (bready[i]) alap_q[i] <= bval[i];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_asap  = asap_q[rd_idx];
  assign rd_alap  = alap_q[rd_idx];
  assign rd_slack = alap_q[rd_idx] - asap_q[rd_idx];
endmodule

// File: rtl/hls_slot_sched_chk.sv
module hls_slot_sched_chk #(
  parameter int STEP_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_ready,
  input logic              done,
  input logic              err,
  input logic [STEP_W-1:0] crit_len,
  input logic [STEP_W-1:0] rd_asap,
  input logic [STEP_W-1:0] rd_alap
);
  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wr_ready) |=> (!wr_ready && !done && !err));

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_ready) |-> $past(start));

  // R1
  idle_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> wr_ready);

  // R6
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_alap >= rd_asap));

  // R5
  inside_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (crit_len != '0)) |-> (rd_alap < crit_len));
endmodule

bind hls_slot_sched hls_slot_sched_chk #(.STEP_W(STEP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .wr_ready(wr_ready),
  .done    (done),
  .err     (err),
  .crit_len(crit_len),
  .rd_asap (rd_asap),
  .rd_alap (rd_alap)
);

// File: tb/test_hls_slot_sched.sv
module test_hls_slot_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [1:0]  wr_lat = '0;
  logic [15:0] wr_pred = '0;
  logic [4:0]  num_nodes = '0;
  logic        start = 1'b0;
  logic        done, err;
  logic [5:0]  crit_len, rd_asap, rd_alap, rd_slack;
  logic [3:0]  rd_idx = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hls_slot_sched i_hls_slot_sched (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_lat(wr_lat), .wr_pred(wr_pred),
    .num_nodes(num_nodes), .start(start), .done(done), .err(err),
    .crit_len(crit_len), .rd_idx(rd_idx), .rd_asap(rd_asap),
    .rd_alap(rd_alap), .rd_slack(rd_slack)
  );

  // reference graph: {latency, predecessor mask, earliest, latest}
  localparam logic [29:0] TBL [11] = '{
    {2'd1, 16'h0000, 6'd0, 6'd0},
    {2'd1, 16'h0000, 6'd0, 6'd0},
    {2'd1, 16'h0003, 6'd1, 6'd1},
    {2'd1, 16'h0004, 6'd2, 6'd2},
    {2'd1, 16'h0048, 6'd3, 6'd3},
    {2'd1, 16'h0000, 6'd0, 6'd1},
    {2'd1, 16'h0020, 6'd1, 6'd2},
    {2'd1, 16'h0000, 6'd0, 6'd2},
    {2'd1, 16'h0080, 6'd1, 6'd3},
    {2'd1, 16'h0000, 6'd0, 6'd2},
    {2'd1, 16'h0200, 6'd1, 6'd3}
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic put(input int a, input int l, input int p);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a[3:0];
    wr_lat   = l[1:0];
    wr_pred  = p[15:0];
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || err) && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk("R8 run ends", int'(done || err), 1);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    num_nodes = n[4:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
  endtask

  task automatic sel(input int idx);
    @(negedge clk);
    rd_idx = idx[3:0];
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 wr_ready", int'(wr_ready), 1);
    chk("R10 done", int'(done), 0);
    chk("R10 err", int'(err), 0);
    chk("R10 crit_len", int'(crit_len), 0);
    sel(4);
    chk("R10 rd_asap", int'(rd_asap), 0);
    rst_n = 1'b1;

    // reference graph, walked from the table
    for (int k = 0; k < 11; k++) put(k, int'(TBL[k][29:28]), int'(TBL[k][27:12]));
    run(11);
    chk("R8 done ref", int'(done), 1);
    chk("R4 crit ref", int'(crit_len), 4);
    for (int k = 0; k < 11; k++) begin
      sel(k);
      chk($sformatf("R3 asap n%0d", k), int'(rd_asap), int'(TBL[k][11:6]));
      chk($sformatf("R5 alap n%0d", k), int'(rd_alap), int'(TBL[k][5:0]));
      chk($sformatf("R6 slack n%0d", k), int'(rd_slack),
          int'(TBL[k][5:0]) - int'(TBL[k][11:6]));
    end
    sel(12);
    chk("R7 inactive n12 asap", int'(rd_asap), 0);

    // multi-cycle chain, mask bit to inactive node 5 on n2
    put(0, 3, 16'h0000);
    put(1, 2, 16'h0001);
    put(2, 1, 16'h0020);
    run(3);
    chk("R4 crit chain", int'(crit_len), 5);
    sel(1);
    chk("R3 asap chain n1", int'(rd_asap), 3);
    chk("R5 alap chain n1", int'(rd_alap), 3);
    sel(0);
    chk("R5 alap chain n0", int'(rd_alap), 0);
    sel(2);
    chk("R7 ignored mask n2 asap", int'(rd_asap), 0);
    chk("R5 alap chain n2", int'(rd_alap), 4);
    chk("R6 slack chain n2", int'(rd_slack), 4);
    sel(4);
    chk("R7 inactive n4 alap", int'(rd_alap), 0);

    // write and second start offered during a run
    @(negedge clk);
    num_nodes = 5'd3;
    start = 1'b1;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr = 4'd1;
    wr_lat = 2'd1;
    wr_pred = 16'h0000;
    #1;
    chk("R1 wr_ready low in run", int'(wr_ready), 0);
    @(negedge clk);
    start = 1'b0;
    wr_valid = 1'b0;
    wait_end();
    chk("R9 crit after ignored start", int'(crit_len), 5);
    run(3);
    sel(1);
    chk("R1 refused write not stored", int'(rd_asap), 3);

    // write accepted on the start edge joins the run
    @(negedge clk);
    num_nodes = 5'd3;
    start = 1'b1;
    wr_valid = 1'b1;
    wr_addr = 4'd2;
    wr_lat = 2'd3;
    wr_pred = 16'h0020;
    @(negedge clk);
    start = 1'b0;
    wr_valid = 1'b0;
    wait_end();
    sel(2);
    chk("R1 same-edge write alap", int'(rd_alap), 2);
    chk("R6 same-edge write slack", int'(rd_slack), 2);

    // latency code 0
    put(0, 0, 16'h0000);
    put(1, 1, 16'h0001);
    run(2);
    sel(1);
    chk("R2 zero latency as 1", int'(rd_asap), 1);
    chk("R2 crit", int'(crit_len), 2);

    // dependency cycle
    put(0, 1, 16'h0002);
    put(1, 1, 16'h0001);
    run(2);
    chk("R8 cycle err", int'(err), 1);
    chk("R8 cycle no done", int'(done), 0);
    chk("R1 ready after err", int'(wr_ready), 1);

    // empty graph
    run(0);
    chk("R8 empty done", int'(done), 1);
    chk("R9 err cleared", int'(err), 0);
    chk("R8 empty crit", int'(crit_len), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule